// File: doc/BRIEF.md
# AUX Reply Timeout Timer

This block measures how long an AUX receiver waits for a reply to start after a request has been sent. Software-side logic asks for a timeout in microseconds. The block turns that value into a compact pair: a 7-bit unit count and a 2-bit scale selector. The scale picks a unit of 8, 16, 32 or 64 µs. The smallest unit is chosen whose range holds the request. The count is rounded up and capped at 127. A request of zero selects a fixed default of 69 units of 8 µs. Each time a new value is stored, the block returns the previously stored timeout in microseconds for one cycle.

A control state machine with three states runs the count:
- `TMR_IDLE` waits for `start`.
- `TMR_RUN` counts `tick_1us` pulses in units of the active scale.
- `TMR_FIRE` is the single cycle in which `timeout` is high.

The named transitions are:
- launch: `TMR_IDLE` to `TMR_RUN` on start.
- restart: `TMR_RUN` to `TMR_RUN` on start.
- halt: `TMR_RUN` to `TMR_IDLE` on reply_seen.
- expire: `TMR_RUN` to `TMR_FIRE` on the final tick.
- settle: `TMR_FIRE` to `TMR_IDLE`.
- relaunch: `TMR_FIRE` to `TMR_RUN` on start.

A zero-length launch, which the encoder never produces, goes straight to `TMR_FIRE`. The count and scale are captured at `start`, so a reload during a count changes only the next one.

Top module: `aux_reply_timer`

## Requirements
- R1: After reset, and after any load with timeout_us = 0, cfg_mul is 0 and cfg_len is 69.
- R2: A load with 1 ≤ timeout_us ≤ 1016 gives cfg_mul = 0 and cfg_len = ceil(timeout_us / 8).
- R3: A load with 1017 ≤ timeout_us ≤ 2032 gives cfg_mul = 1 and cfg_len = ceil(timeout_us / 16).
- R4: A load with 2033 ≤ timeout_us ≤ 4064 gives cfg_mul = 2 and cfg_len = ceil(timeout_us / 32).
- R5: A load with timeout_us > 4064 gives cfg_mul = 3 and cfg_len = min(127, ceil(timeout_us / 64)).
- R6: The cycle after a load, prev_valid is high for exactly one cycle. In that cycle prev_us equals the old cfg_len × (8 << old cfg_mul). prev_us is unchanged when there is no load.
- R7: The block counts tick_1us pulses that arrive after the start cycle. busy is high while counting. timeout is high for exactly one cycle, the cycle after the edge that takes the (cfg_len × (8 << cfg_mul))-th tick, and not earlier.
- R8: reply_seen while counting returns busy to 0 on the next cycle. No timeout follows, however many ticks arrive afterwards.
- R9: A load during a count does not change that count's expiry. The new setting applies from the next start.
- R10: start during a count discards the ticks already counted and begins a full new count. start has priority over reply_seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Request sent; begin a new count |
| reply_seen | input | 1 | Start of a reply detected; stop the count |
| cfg_load | input | 1 | Store a new timeout from timeout_us |
| timeout_us | input | 16 | Requested timeout in microseconds |
| cfg_len | output | 7 | Stored unit count |
| cfg_mul | output | 2 | Stored scale selector (unit = 8 << cfg_mul µs) |
| prev_us | output | 13 | Previously stored timeout in µs, valid with prev_valid |
| prev_valid | output | 1 | One-cycle pulse after each load |
| busy | output | 1 | Count in progress |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume the following about the inputs:
- start, reply_seen and cfg_load are judged one cycle at a time.
- A start in the same cycle as another event wins. The pulse-width and halt properties therefore exclude cycles that carry start.
- timeout_us is meaningful only in a cycle with cfg_load.

The stimulus keeps to these rules:
- Every control input is driven as a single-cycle pulse, away from the clock edge.
- Ticks are never driven in a start cycle, so the expected tick count is exact.
- Random timeouts are drawn across the lower three scale ranges. Directed loads hit every range edge and the clamp.

// File: rtl/aux_to_pkg.sv
package aux_to_pkg;

    localparam int TO_US_W     = 16;
    localparam int TO_LEN_W    = 7;
    localparam int TO_MUL_W    = 2;
    localparam int TO_BASE_SH  = 3;
    localparam int TO_DEF_LEN  = 69;
    localparam int TO_MAX_LEN  = 127;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_FIRE = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/aux_to_encode.sv
module aux_to_encode #(
    parameter int US_W    = 16,
    parameter int LEN_W   = 7,
    parameter int MUL_W   = 2,
    parameter int BASE_SH = 3,
    parameter int DEF_LEN = 69,
    parameter int MAX_LEN = 127
) (
    input  logic [US_W-1:0]  req_us,
    output logic [LEN_W-1:0] enc_len,
    output logic [MUL_W-1:0] enc_mul
);

    localparam int NUM_MUL = 1 << MUL_W;
    localparam int SUM_W   = US_W + 1;

    logic [SUM_W-1:0]   req_ext;
    logic [NUM_MUL-1:0] fits;
    logic [SUM_W-1:0]   ceil_v [NUM_MUL];
    logic [MUL_W-1:0]   sel;
    logic [SUM_W-1:0]   raw_len;
    logic               found;

    assign req_ext = SUM_W'(req_us);

    // One range per scale: upper bound and rounded-up unit count.
    for (genvar k = 0; k < NUM_MUL; k++) begin : g_range
        localparam int SH    = BASE_SH + k;
        localparam int LIMIT = MAX_LEN << SH;
        if (k == NUM_MUL - 1) begin : g_top
            assign fits[k] = 1'b1;
        end else begin : g_mid
            assign fits[k] = (req_ext <= SUM_W'(LIMIT));
        end
        assign ceil_v[k] = (req_ext + SUM_W'((1 << SH) - 1)) >> SH;
    end

    // Smallest scale whose range holds the request.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_MUL; i++) begin
            if (!found && fits[i]) begin
                sel   = MUL_W'(i);
                found = 1'b1;
            end
        end
    end

    assign raw_len = ceil_v[sel];

    always_comb begin
        if (req_us == '0) begin
            enc_mul = '0;
            enc_len = LEN_W'(DEF_LEN);
        end else begin
            enc_mul = sel;
            enc_len = (raw_len > SUM_W'(MAX_LEN)) ? LEN_W'(MAX_LEN)
                                                  : raw_len[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/aux_to_cfg.sv
module aux_to_cfg #(
    parameter int US_W    = 16,
    parameter int LEN_W   = 7,
    parameter int MUL_W   = 2,
    parameter int BASE_SH = 3,
    parameter int DEF_LEN = 69,
    parameter int MAX_LEN = 127,
    parameter int PREV_W  = LEN_W + BASE_SH + (1 << MUL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [US_W-1:0]   req_us,
    input  logic [LEN_W-1:0]  enc_len,
    input  logic [MUL_W-1:0]  enc_mul,
    output logic [LEN_W-1:0]  cfg_len,
    output logic [MUL_W-1:0]  cfg_mul,
    output logic [PREV_W-1:0] prev_us,
    output logic              prev_valid
);

    localparam int NUM_MUL  = 1 << MUL_W;
    localparam int LOW_TOP  = MAX_LEN << BASE_SH;
    localparam int HIGH_BOT = MAX_LEN << (BASE_SH + NUM_MUL - 2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_len    <= LEN_W'(DEF_LEN);
            cfg_mul    <= '0;
            prev_us    <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_valid <= load;
            if (load) begin
                prev_us <= PREV_W'(cfg_len) << (BASE_SH + int'(cfg_mul));
                cfg_len <= enc_len;
                cfg_mul <= enc_mul;
            end
        end
    end

    AST_ZERO_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && req_us == '0) |=> (cfg_len == LEN_W'(DEF_LEN) && cfg_mul == '0)); // R1

    AST_LOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && req_us != '0 && int'(req_us) <= LOW_TOP) |=> (cfg_mul == '0)); // R2

    AST_TOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && int'(req_us) > HIGH_BOT) |=> (cfg_mul == MUL_W'(NUM_MUL - 1))); // R5

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_len) <= MAX_LEN && cfg_len != '0)); // R5

    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(prev_us) && !prev_valid)); // R6

endmodule

// File: rtl/aux_to_timer.sv
module aux_to_timer
    import aux_to_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int MUL_W   = 2,
    parameter int BASE_SH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             reply_seen,
    input  logic [LEN_W-1:0] len_in,
    input  logic [MUL_W-1:0] mul_in,
    output logic             busy,
    output logic             timeout
);

    localparam int NUM_MUL = 1 << MUL_W;
    localparam int SUB_W   = BASE_SH + NUM_MUL - 1;

    tmr_state_e       state_q, state_d;
    logic [LEN_W-1:0] act_len;
    logic [MUL_W-1:0] act_mul;
    logic [SUB_W-1:0] sub_q;
    logic [LEN_W-1:0] units_q;
    logic [SUB_W-1:0] unit_last;
    logic             unit_done;
    logic             last_unit;
    logic             launch_state;

    assign unit_last = SUB_W'((1 << (BASE_SH + int'(act_mul))) - 1);
    assign unit_done = tick && (sub_q == unit_last);
    assign last_unit = (units_q == act_len - LEN_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic; start always wins
    always_comb begin
        launch_state = (len_in == '0) ? 1'b1 : 1'b0;
        state_d      = state_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (start) state_d = launch_state ? TMR_FIRE : TMR_RUN;
            end
            TMR_RUN: begin
                if (start)                       state_d = launch_state ? TMR_FIRE : TMR_RUN;
                else if (reply_seen)             state_d = TMR_IDLE;
                else if (unit_done && last_unit) state_d = TMR_FIRE;
            end
            TMR_FIRE: begin
                if (start) state_d = launch_state ? TMR_FIRE : TMR_RUN;
                else       state_d = TMR_IDLE;
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // Unit counters and the setting captured at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len <= '0;
            act_mul <= '0;
            sub_q   <= '0;
            units_q <= '0;
        end else if (start) begin
            act_len <= len_in;
            act_mul <= mul_in;
            sub_q   <= '0;
            units_q <= '0;
        end else if (state_q == TMR_RUN && tick) begin
            if (unit_done) begin
                sub_q   <= '0;
                units_q <= units_q + LEN_W'(1);
            end else begin
                sub_q   <= sub_q + SUB_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        timeout = 1'b0;
        unique case (state_q)
            TMR_IDLE: ;
            TMR_RUN:  busy    = 1'b1;
            TMR_FIRE: timeout = 1'b1;
            default: ;
        endcase
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !start) |=> !timeout); // R7

    AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (units_q < act_len)); // R7

    AST_REPLY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reply_seen && !start) |=> (!busy && !timeout)); // R8

    AST_ACTIVE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ($stable(act_len) && $stable(act_mul))); // R9

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_in != '0) |=> (busy && units_q == '0 && sub_q == '0)); // R10

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
    import aux_to_pkg::*;
#(
    parameter int US_W    = TO_US_W,
    parameter int LEN_W   = TO_LEN_W,
    parameter int MUL_W   = TO_MUL_W,
    parameter int BASE_SH = TO_BASE_SH,
    parameter int DEF_LEN = TO_DEF_LEN,
    parameter int MAX_LEN = TO_MAX_LEN,
    parameter int PREV_W  = LEN_W + BASE_SH + (1 << MUL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              start,
    input  logic              reply_seen,
    input  logic              cfg_load,
    input  logic [US_W-1:0]   timeout_us,
    output logic [LEN_W-1:0]  cfg_len,
    output logic [MUL_W-1:0]  cfg_mul,
    output logic [PREV_W-1:0] prev_us,
    output logic              prev_valid,
    output logic              busy,
    output logic              timeout
);

    logic [LEN_W-1:0] enc_len;
    logic [MUL_W-1:0] enc_mul;

    aux_to_encode #(
        .US_W(US_W), .LEN_W(LEN_W), .MUL_W(MUL_W),
        .BASE_SH(BASE_SH), .DEF_LEN(DEF_LEN), .MAX_LEN(MAX_LEN)
    ) u_encode (
        .req_us  (timeout_us),
        .enc_len (enc_len),
        .enc_mul (enc_mul)
    );

    aux_to_cfg #(
        .US_W(US_W), .LEN_W(LEN_W), .MUL_W(MUL_W), .BASE_SH(BASE_SH),
        .DEF_LEN(DEF_LEN), .MAX_LEN(MAX_LEN), .PREV_W(PREV_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .req_us     (timeout_us),
        .enc_len    (enc_len),
        .enc_mul    (enc_mul),
        .cfg_len    (cfg_len),
        .cfg_mul    (cfg_mul),
        .prev_us    (prev_us),
        .prev_valid (prev_valid)
    );

    aux_to_timer #(
        .LEN_W(LEN_W), .MUL_W(MUL_W), .BASE_SH(BASE_SH)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1us),
        .start      (start),
        .reply_seen (reply_seen),
        .len_in     (cfg_len),
        .mul_in     (cfg_mul),
        .busy       (busy),
        .timeout    (timeout)
    );

endmodule

// File: tb/aux_reply_timer_tb.sv
module aux_reply_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        start = 1'b0;
    logic        reply_seen = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] timeout_us = '0;
    logic [6:0]  cfg_len;
    logic [1:0]  cfg_mul;
    logic [12:0] prev_us;
    logic        prev_valid;
    logic        busy;
    logic        timeout;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int old_len = 69;
    int old_mul = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_reply_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .start(start),
        .reply_seen(reply_seen), .cfg_load(cfg_load), .timeout_us(timeout_us),
        .cfg_len(cfg_len), .cfg_mul(cfg_mul), .prev_us(prev_us),
        .prev_valid(prev_valid), .busy(busy), .timeout(timeout)
    );

    function automatic int e_mul(int t);
        if (t <= 1016) return 0;
        if (t <= 2032) return 1;
        if (t <= 4064) return 2;
        return 3;
    endfunction

    function automatic int e_len(int t);
        int u;
        int l;
        if (t == 0) return 69;
        u = 8 << e_mul(t);
        l = (t + u - 1) / u;
        return (l > 127) ? 127 : l;
    endfunction

    function automatic string tag_of(int t);
        if (t == 0)    return "R1";
        if (t <= 1016) return "R2";
        if (t <= 2032) return "R3";
        if (t <= 4064) return "R4";
        return "R5";
    endfunction

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(int t);
        @(negedge clk);
        cfg_load   = 1'b1;
        timeout_us = t[15:0];
        @(negedge clk);
        cfg_load = 1'b0;
        check_eq(tag_of(t), int'(cfg_len), e_len(t));
        check_eq(tag_of(t), int'(cfg_mul), e_mul(t));
        check_eq("R6", int'(prev_us), old_len * (8 << old_mul));
        check_eq("R6", int'(prev_valid), 1);
        old_len = e_len(t);
        old_mul = e_mul(t);
        @(negedge clk);
        check_eq("R6", int'(prev_valid), 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Starts at a negedge, returns at the negedge after the tick edge.
    task automatic give_tick(int gap, inout int early);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (timeout) early++;
        end
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
    endtask

    task automatic run_count(int n, int maxgap, string req, int load_at, int load_t);
        int early = 0;
        pulse_start();
        check_eq(req, int'(busy), 1);
        for (int i = 1; i <= n; i++) begin
            give_tick($urandom_range(0, maxgap), early);
            if (i < n && timeout) early++;
            if (i == load_at) do_load(load_t);
        end
        check_eq(req, int'(timeout), 1);
        check_eq(req, early, 0);
        @(negedge clk);
        check_eq(req, int'(timeout), 0);
        check_eq(req, int'(busy), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int early;
        int t;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", int'(cfg_len), 69);
        check_eq("R1", int'(cfg_mul), 0);
        check_eq("R7", int'(busy), 0);
        check_eq("R7", int'(timeout), 0);
        check_eq("R6", int'(prev_valid), 0);

        // Encoding at every range edge and the clamp (R1..R5)
        do_load(0);
        do_load(1);
        run_count(8, 1, "R7", -1, 0);
        do_load(1016);
        do_load(1017);
        run_count(1024, 0, "R7", -1, 0);
        do_load(2032);
        do_load(2033);
        do_load(4064);
        do_load(4065);
        do_load(9000);
        run_count(8128, 0, "R5", -1, 0);

        // R8: reply stops the count
        do_load(100);
        early = 0;
        pulse_start();
        for (int i = 0; i < 50; i++) give_tick(0, early);
        @(negedge clk);
        reply_seen = 1'b1;
        @(negedge clk);
        reply_seen = 1'b0;
        check_eq("R8", int'(busy), 0);
        for (int i = 0; i < 120; i++) begin
            give_tick(0, early);
            if (timeout || busy) early++;
        end
        check_eq("R8", early, 0);

        // R10: restart discards earlier ticks
        pulse_start();
        for (int i = 0; i < 60; i++) give_tick(0, early);
        run_count(104, 1, "R10", -1, 0);

        // R9: load mid-count has no effect until next start
        do_load(16);
        run_count(16, 1, "R9", 5, 8);
        run_count(8, 1, "R9", -1, 0);

        // Random timeouts across the lower ranges
        for (int r = 0; r < 12; r++) begin
            t = $urandom_range(0, 3000);
            do_load(t);
            run_count(e_len(t) * (8 << e_mul(t)), $urandom_range(0, 1), "R7", -1, 0);
        end

        done = 1'b1;
        finish_run();
    end

endmodule